// File: doc/BRIEF.md
# Serial Transmitter with Gated Carrier Output

This block turns one byte into an asynchronous serial frame: a low start bit, seven or eight data bits with the least significant bit first, an optional even or odd parity bit, and one or two high stop bits. It has no queue. A byte is taken only while the transmitter is idle, and `busy` stays high from the cycle after the load until the last stop bit ends. Bit timing comes from an external one-cycle enable, `bit_tick`. Each bit moves to the next on that enable.

For infrared-style links the serial level can be gated with a square-wave carrier. A counter runs from 0 to the 8-bit period value and flips the carrier at each wrap, so one carrier period is 2×(period+1) clocks. The carrier restarts at every frame load, which fixes its phase. A polarity select puts the carrier bursts either on the low bits or on the high bits. An invert control is applied last and also inverts the idle level.

Top module: `uart_carrier_tx`

## Requirements
- R1: After reset, `busy` is 0 and `tx_out` equals NOT `out_inv`. While idle the unmodulated line level is 1.
- R2: A `wr_en` pulse while idle makes `busy` 1 on the next cycle, and the line then shows the start bit (level 0).
- R3: After the start bit the data bits go out least significant bit first. There are 8 of them when `cfg_len7`=0, and only `wr_data[6:0]` goes out when `cfg_len7`=1.
- R4: With `cfg_par_en`=1, a parity bit follows the data bits. When `cfg_par_odd`=0 it makes the count of ones over the sent data bits and the parity bit even. When `cfg_par_odd`=1 it makes that count odd.
- R5: Stop bits are level 1. There is one when `cfg_stop2`=0 and two when `cfg_stop2`=1.
- R6: While busy, the line moves to the next bit only on a cycle with `bit_tick`=1. `busy` falls on the cycle after the tick that ends the last stop bit.
- R7: A `wr_en` while busy is ignored and leaves the frame in progress unchanged. A `bit_tick` while idle is ignored.
- R8: With `car_en`=0 the output is the plain frame, whatever `car_pol` and `car_per` hold.
- R9: The carrier is 1 for the `car_per`+1 clocks that follow a frame load. After that it toggles every `car_per`+1 clocks.
- R10: With `car_en`=1 and `car_pol`=0, bits at level 0 output the carrier and bits at level 1 output 1. With `car_pol`=1, bits at level 1 output the carrier and bits at level 0 output 0.
- R11: `out_inv`=1 inverts the final output after modulation, in every state.
- R12: The carrier is applied only while busy. When idle the output holds steady at NOT `out_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Bit-rate enable, one cycle per bit time |
| wr_en | input | 1 | Load strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| cfg_len7 | input | 1 | 1: seven data bits |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| car_en | input | 1 | Carrier gating enable |
| car_pol | input | 1 | 0: burst on low bits, 1: burst on high bits |
| car_per | input | 8 | Carrier half-period minus one, in clocks |
| out_inv | input | 1 | Invert the final output |
| tx_out | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
A wrong shift, bit counter or phase state shows up on `tx_out` within one bit time as a wrong level. It can also appear as a frame that ends a bit early or late, which `busy` reveals on the cycle after the closing tick. A carrier counter that is off by one or keeps a stale phase after a load gives an edge that lands on the wrong clock. The bench compares every clock against a model indexed from the load, so such an error is caught within one carrier half-period. A write accepted while busy corrupts the next bit, and a tick taken while idle raises `busy`, so both show within a cycle.

// File: rtl/uct_pkg.sv
package uct_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } phase_e;
endpackage

// File: rtl/uct_framer.sv
module uct_framer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_short,
    input  logic              cfg_stop2,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              line,
    output logic              busy,
    output logic              restart
);
    import uct_pkg::*;

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              short_len;
        logic              stop2;
        logic              par_en;
        logic              line;
    } fr_t;

    localparam fr_t RESET_ST = '{phase: PH_IDLE, cnt: '0, sh: '0, par: 1'b0,
                                 short_len: 1'b0, stop2: 1'b0, par_en: 1'b0,
                                 line: 1'b1};

    fr_t st_d, st_q;
    logic accept;
    logic [DATA_W-1:0] masked;
    logic [CNT_W-1:0]  last_idx;

    always_comb begin
        st_d     = st_q;
        accept   = wr_en && (st_q.phase == PH_IDLE);
        masked   = cfg_short ? (wr_data & {1'b0, {(DATA_W-1){1'b1}}}) : wr_data;
        last_idx = st_q.short_len ? LAST_SHORT : LAST_FULL;
        if (accept) begin
            st_d.phase     = PH_START;
            st_d.cnt       = '0;
            st_d.sh        = masked;
            st_d.par       = (^masked) ^ cfg_par_odd;
            st_d.short_len = cfg_short;
            st_d.stop2     = cfg_stop2;
            st_d.par_en    = cfg_par_en;
            st_d.line      = 1'b0;
        end else if (bit_tick) begin
            unique case (st_q.phase)
                PH_START: begin
                    st_d.phase = PH_DATA;
                    st_d.cnt   = '0;
                    st_d.line  = st_q.sh[0];
                    st_d.sh    = st_q.sh >> 1;
                end
                PH_DATA: begin
                    if (st_q.cnt == last_idx) begin
                        if (st_q.par_en) begin
                            st_d.phase = PH_PARITY;
                            st_d.line  = st_q.par;
                        end else begin
                            st_d.phase = PH_STOP;
                            st_d.line  = 1'b1;
                            st_d.cnt   = '0;
                        end
                    end else begin
                        st_d.cnt  = st_q.cnt + CNT_W'(1);
                        st_d.line = st_q.sh[0];
                        st_d.sh   = st_q.sh >> 1;
                    end
                end
                PH_PARITY: begin
                    st_d.phase = PH_STOP;
                    st_d.line  = 1'b1;
                    st_d.cnt   = '0;
                end
                PH_STOP: begin
                    if (st_q.stop2 && (st_q.cnt == '0)) begin
                        st_d.cnt = CNT_W'(1);
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.line  = 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign line    = st_q.line;
    assign busy    = (st_q.phase != PH_IDLE);
    assign restart = accept;

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> (busy && !line));
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> (busy && $stable(line)));
    p_stay_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> !busy);
endmodule

// File: rtl/uct_carrier.sv
module uct_carrier #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PER_W-1:0] per,
    output logic             car
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             car;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d = cg_q;
        if (restart) begin
            cg_d.cnt = '0;
            cg_d.car = 1'b1;
        end else if (cg_q.cnt == per) begin
            cg_d.cnt = '0;
            cg_d.car = ~cg_q.car;
        end else begin
            cg_d.cnt = cg_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '{cnt: '0, car: 1'b1};
        else        cg_q <= cg_d;
    end

    assign car = cg_q.car;

    p_car_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (car && (cg_q.cnt == '0)));
    p_car_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (cg_q.cnt != per)) |=> (car == $past(car)));
    p_car_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (cg_q.cnt == per)) |=> (car != $past(car)));
endmodule

// File: rtl/uart_carrier_tx.sv
module uart_carrier_tx #(
    parameter int DATA_W = 8,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len7,
    input  logic              cfg_stop2,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              car_en,
    input  logic              car_pol,
    input  logic [PER_W-1:0]  car_per,
    input  logic              out_inv,
    output logic              tx_out,
    output logic              busy
);
    logic plain_line;
    logic frame_busy;
    logic frame_restart;
    logic carrier;
    logic mod_level;

    uct_framer #(.DATA_W(DATA_W)) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg_short   (cfg_len7),
        .cfg_stop2   (cfg_stop2),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .line        (plain_line),
        .busy        (frame_busy),
        .restart     (frame_restart)
    );

    uct_carrier #(.PER_W(PER_W)) i_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_restart),
        .per     (car_per),
        .car     (carrier)
    );

    always_comb begin
        if (!car_en || !frame_busy) mod_level = plain_line;
        else if (car_pol)           mod_level = plain_line & carrier;
        else                        mod_level = plain_line | carrier;
    end

    assign tx_out = mod_level ^ out_inv;
    assign busy   = frame_busy;

    p_idle_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_out == !out_inv));
endmodule

// File: tb/test_uart_carrier_tx.sv
module test_uart_carrier_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic car_en = 1'b0, car_pol = 1'b0, out_inv = 1'b0;
    logic [7:0] car_per = '0;
    logic tx_out, busy;

    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;

    uart_carrier_tx i_uart_carrier_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .car_en(car_en),
        .car_pol(car_pol), .car_per(car_per), .out_inv(out_inv),
        .tx_out(tx_out), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b at cycle %0d", req, got, exp, cycles);
        end
    endtask

    function automatic logic exp_car(input int j, input int per);
        return ((j / (per + 1)) % 2) == 0;
    endfunction

    function automatic logic exp_level(input logic b, input int j, input int per,
                                       input logic cen, input logic pol, input logic inv);
        logic m;
        if (!cen)     m = b;
        else if (pol) m = b & exp_car(j, per);
        else          m = b | exp_car(j, per);
        return m ^ inv;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic send_frame(input logic [7:0] d, input logic l7, input logic s2,
                              input logic pe, input logic po, input logic cen,
                              input logic pol, input logic [7:0] per, input logic inv,
                              input int hold, input logic intrude, input string tag);
        logic bits [0:11];
        int n = 0;
        int j = 0;
        int h;
        logic par;
        par = (l7 ? ^d[6:0] : ^d) ^ po;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < (l7 ? 7 : 8); i++) begin bits[n] = d[i]; n++; end
        if (pe) begin bits[n] = par; n++; end
        bits[n] = 1'b1; n++;
        if (s2) begin bits[n] = 1'b1; n++; end
        cfg_len7 = l7; cfg_stop2 = s2; cfg_par_en = pe; cfg_par_odd = po;
        car_en = cen; car_pol = pol; car_per = per; out_inv = inv;
        wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        wr_data = ~d;
        for (int k = 0; k < n; k++) begin
            h = (hold > 0) ? hold : int'($urandom_range(4, 1));
            for (int c = 0; c < h; c++) begin
                if (j == 0) begin
                    check(busy, 1'b1, "R2");
                    check(tx_out, exp_level(1'b0, j, per, cen, pol, inv), "R2");
                end else begin
                    check(busy, 1'b1, tag);
                    check(tx_out, exp_level(bits[k], j, per, cen, pol, inv), tag);
                end
                if (intrude && k == 2 && c == 0) begin
                    wr_en = 1'b1; wr_data = 8'h00;
                end
                if (c == h - 1) bit_tick = 1'b1;
                @(posedge clk); @(negedge clk);
                bit_tick = 1'b0; wr_en = 1'b0;
                j++;
            end
        end
        check(busy, 1'b0, "R6");
        check(tx_out, ~inv, "R12");
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(busy, 1'b0, "R1");
        check(tx_out, 1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(busy, 1'b0, "R1");
        check(tx_out, 1'b1, "R1");

        // R3: 8 data bits, no parity, one stop
        send_frame(8'hA5, 0, 0, 0, 0, 0, 0, 8'd0, 0, 2, 0, "R3");
        send_frame(8'h01, 0, 0, 0, 0, 0, 0, 8'd0, 0, 1, 0, "R3");
        // R3: seven bits, MSB dropped
        send_frame(8'hFF, 1, 0, 0, 0, 0, 0, 8'd0, 0, 2, 0, "R3");
        // R4: even and odd parity
        send_frame(8'h07, 0, 0, 1, 0, 0, 0, 8'd0, 0, 2, 0, "R4");
        send_frame(8'h07, 0, 0, 1, 1, 0, 0, 8'd0, 0, 2, 0, "R4");
        send_frame(8'hC3, 1, 0, 1, 1, 0, 0, 8'd0, 0, 3, 0, "R4");
        // R5: two stop bits
        send_frame(8'h3C, 0, 1, 1, 0, 0, 0, 8'd0, 0, 3, 0, "R5");
        send_frame(8'h55, 1, 1, 0, 0, 0, 0, 8'd0, 0, 2, 0, "R5");
        // R8: carrier disabled, polarity and period set
        send_frame(8'h96, 0, 0, 1, 0, 0, 1, 8'd1, 0, 5, 0, "R8");
        // R9: long bits expose carrier period from load
        send_frame(8'h00, 0, 0, 0, 0, 1, 0, 8'd5, 0, 20, 0, "R9");
        send_frame(8'hF0, 0, 0, 0, 0, 1, 0, 8'd0, 0, 6, 0, "R9");
        // R10: burst on high bits
        send_frame(8'hFF, 0, 1, 1, 1, 1, 1, 8'd2, 0, 9, 0, "R10");
        send_frame(8'h5A, 0, 0, 1, 0, 1, 0, 8'd2, 0, 7, 0, "R10");
        // R11: inversion after modulation
        send_frame(8'h69, 0, 0, 1, 0, 1, 1, 8'd1, 1, 5, 0, "R11");
        send_frame(8'h69, 1, 1, 0, 0, 0, 0, 8'd1, 1, 3, 0, "R11");
        // R7: write while busy ignored
        send_frame(8'hFF, 0, 0, 0, 0, 0, 0, 8'd0, 0, 3, 1, "R7");

        // R7: tick while idle ignored
        out_inv = 1'b0; car_en = 1'b0;
        bit_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_tick = 1'b0;
        check(busy, 1'b0, "R7");
        check(tx_out, 1'b1, "R7");

        // R12: idle with carrier enabled stays steady
        car_en = 1'b1; car_pol = 1'b1; car_per = 8'd0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(tx_out, 1'b1, "R12");
        end
        out_inv = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tx_out, 1'b0, "R11");
        end

        // R6: random frames with random bit lengths
        for (int f = 0; f < 40; f++) begin
            send_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom),
                       8'($urandom_range(3, 0)), 1'($urandom), 0,
                       1'($urandom), "R6");
        end

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule